// File: doc/BRIEF.md
# Link Turnaround Controller

This block hands the direction of a bidirectional low-power data lane from one end of the link to the other. It plays both roles of the procedure, one after the other. When it owns the lane and its user asks for a handover, it sends a request made of low-power line states. It then holds the bridge state and lets go of the lines. When the lane belongs to the far end, it watches the synchronized receive lines for the same request. It waits inside a bounded window, drives the bridge state, and takes the lane back.

All durations are counted in clock cycles as multiples of a programmable low-power period count (`lpx_cnt`). The far-end line state arrives on `lp_rx`. The local line state leaves on `lp_tx`, and `drive_en` enables the local drivers. A line pair is written `{P,N}`: stop state LP-11 = 2'b11, LP-10 = 2'b10, bridge LP-00 = 2'b00, LP-01 = 2'b01. Escape commands and contention detection are outside this block.

Top module: `lane_turnaround`

## Requirements
- R1: In reset, with the default `START_OWNER` = 1, the block drives the lane: `drive_en` = 1, `lp_tx` = 2'b11 and `lane_owned` = 1, with `rel_done`, `acc_done` and `ta_err` low.
- R2: A one-cycle `rel_req` while `lane_owned` = 1 makes `lp_tx` show 2'b10, 2'b00 and 2'b10, each for LPX cycles. Bridge 2'b00 then follows for 4×LPX cycles. In the cycle after the bridge, `drive_en` falls and `rel_done` pulses for one cycle.
- R3: `rel_req` has no effect while the lane is not owned: `drive_en`, `lp_tx` and `rel_done` stay unchanged.
- R4: As receiver, after the synchronized line has gone 2'b11 → 2'b10 → 2'b00 → 2'b10, the block takes control at the first clock edge that meets two conditions. At least LPX edges must have passed since the edge that observed the last 2'b10, and the synchronized line must be 2'b00. If the far end drives its last 2'b10 for m cycles, `drive_en` rises `SYNC_STAGES`+1+max(LPX, m) cycles after it is first driven.
- R5: Taking control is still allowed at exactly 2×LPX edges. If no 2'b00 has been seen by then, or the line returns to 2'b11 or 2'b01 inside the window, `ta_err` pulses for one cycle. The block then stays receiver and re-arms only after seeing 2'b11.
- R6: After taking control, the block drives 2'b00 for 5×LPX cycles and then 2'b10 for LPX cycles. It then enters 2'b11 with `lane_owned` = 1 and a one-cycle `acc_done`.
- R7: While the block owns the lane in the stop state, `lp_rx` is ignored.
- R8: An `lpx_cnt` of 0 is treated as 1.
- R9: `drive_en` changes only when the release bridge ends or when control is taken on an observed 2'b00. While `drive_en` = 0, `lp_tx` rests at 2'b11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| lpx_cnt | input | LPX_W | Low-power period length in clock cycles (0 acts as 1) |
| rel_req | input | 1 | Request to hand the lane to the far end |
| lp_rx | input | 2 | Far-end line state {P,N}, asynchronous |
| lp_tx | output | 2 | Local line state {P,N} |
| drive_en | output | 1 | Local line drivers enabled |
| lane_owned | output | 1 | Block owns the lane and rests in the stop state |
| rel_done | output | 1 | One-cycle pulse when the lane has been released |
| acc_done | output | 1 | One-cycle pulse when the lane has been taken over |
| ta_err | output | 1 | One-cycle pulse when the acceptance window fails |

## Verification
The handover is run in both directions and with three LPX values, including the zero count that must behave as one. This separates true multiples of LPX from fixed cycle counts. The far end's final 2'b10 is held for one cycle, exactly LPX, exactly 2×LPX and 2×LPX+1 cycles. These cases show in turn the enforced minimum wait, the nominal case, the last legal edge of the window, and the timeout error with its later recovery. A request while not owning the lane and line activity while owning it confirm that neither input leaks into the outputs.

// File: rtl/lt_pkg.sv
package lt_pkg;

   localparam logic [1:0] LINE_STOP   = 2'b11;
   localparam logic [1:0] LINE_P1     = 2'b10;
   localparam logic [1:0] LINE_BRIDGE = 2'b00;
   localparam logic [1:0] LINE_N1     = 2'b01;

   typedef enum logic [3:0] {
      LT_TX_STOP,
      LT_REQ_A,
      LT_REQ_B,
      LT_REQ_C,
      LT_GO,
      LT_RX_IDLE,
      LT_RX_STOP,
      LT_RX_A,
      LT_RX_B,
      LT_RX_SURE,
      LT_TG_BRIDGE,
      LT_TG_MARK
   } lt_state_e;

endpackage

// File: rtl/lt_line_sync.sv
module lt_line_sync #(
   parameter int STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [1:0] line_in,
   output logic [1:0] line_out
);

   generate
      if (STAGES == 0) begin : g_bypass
         assign line_out = line_in;
      end else begin : g_chain
         logic [1:0] stg_q [STAGES];
         for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
               always_ff @(posedge clk or negedge rst_n) begin
                  if (!rst_n) stg_q[0] <= 2'b11;
                  else        stg_q[0] <= line_in;
               end
            end else begin : g_next
               always_ff @(posedge clk or negedge rst_n) begin
                  if (!rst_n) stg_q[i] <= 2'b11;
                  else        stg_q[i] <= stg_q[i-1];
               end
            end
         end
         assign line_out = stg_q[STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/lt_lpx_timer.sv
module lt_lpx_timer #(
   parameter int LPX_W = 8,
   localparam int TW   = LPX_W + 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [LPX_W-1:0] lpx_cnt,
   input  logic [2:0]       mult,
   input  logic             clr,
   output logic             one_lpx,
   output logic             span_done
);

   logic [TW-1:0] lpx_eff;
   logic [TW-1:0] target;
   logic [TW-1:0] t_q;
   logic [TW-1:0] t_p1;

   // a zero period count is promoted to one cycle
   assign lpx_eff   = (lpx_cnt == '0) ? TW'(1) : TW'(lpx_cnt);
   assign target    = TW'(mult) * lpx_eff;
   assign t_p1      = t_q + TW'(1);
   assign one_lpx   = (t_p1 >= lpx_eff);
   assign span_done = (t_p1 >= target);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            t_q <= '0;
      else if (clr)          t_q <= '0;
      else if (t_q != '1)    t_q <= t_p1;
   end

endmodule

// File: rtl/lane_turnaround.sv
module lane_turnaround
   import lt_pkg::*;
#(
   parameter int LPX_W       = 8,
   parameter int SYNC_STAGES = 2,
   parameter bit START_OWNER = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [LPX_W-1:0] lpx_cnt,
   input  logic             rel_req,
   input  logic [1:0]       lp_rx,
   output logic [1:0]       lp_tx,
   output logic             drive_en,
   output logic             lane_owned,
   output logic             rel_done,
   output logic             acc_done,
   output logic             ta_err
);

   localparam lt_state_e RST_ST = START_OWNER ? LT_TX_STOP : LT_RX_IDLE;

   initial begin : param_chk
      assert (LPX_W >= 2) else $error("LPX_W must be at least 2");
      assert (SYNC_STAGES <= 4) else $error("SYNC_STAGES must not exceed 4");
   end

   lt_state_e  state_q, state_d;
   logic [1:0] line_s;
   logic [2:0] mult;
   logic       one_lpx, span_done, clr;
   logic       err_c, take_c;
   logic       rel_q, acc_q, err_q;

   lt_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk      (clk),
      .rst_n    (rst_n),
      .line_in  (lp_rx),
      .line_out (line_s)
   );

   lt_lpx_timer #(.LPX_W(LPX_W)) u_timer (
      .clk       (clk),
      .rst_n     (rst_n),
      .lpx_cnt   (lpx_cnt),
      .mult      (mult),
      .clr       (clr),
      .one_lpx   (one_lpx),
      .span_done (span_done)
   );

   assign clr    = (state_d != state_q);
   assign take_c = (state_q == LT_RX_SURE) && one_lpx && (line_s == LINE_BRIDGE);

   always_comb begin
      state_d = state_q;
      mult    = 3'd1;
      err_c   = 1'b0;
      case (state_q)
         LT_TX_STOP:   if (rel_req) state_d = LT_REQ_A;
         LT_REQ_A:     if (span_done) state_d = LT_REQ_B;
         LT_REQ_B:     if (span_done) state_d = LT_REQ_C;
         LT_REQ_C:     if (span_done) state_d = LT_GO;
         LT_GO: begin
            mult = 3'd4;
            if (span_done) state_d = LT_RX_IDLE;
         end
         LT_RX_IDLE:   if (line_s == LINE_STOP) state_d = LT_RX_STOP;
         LT_RX_STOP: begin
            if (line_s == LINE_P1)          state_d = LT_RX_A;
            else if (line_s != LINE_STOP)   state_d = LT_RX_IDLE;
         end
         LT_RX_A: begin
            if (line_s == LINE_BRIDGE)      state_d = LT_RX_B;
            else if (line_s != LINE_P1)     state_d = LT_RX_IDLE;
         end
         LT_RX_B: begin
            if (line_s == LINE_P1)          state_d = LT_RX_SURE;
            else if (line_s != LINE_BRIDGE) state_d = LT_RX_IDLE;
         end
         LT_RX_SURE: begin
            mult = 3'd2;
            if (take_c) begin
               state_d = LT_TG_BRIDGE;
            end else if (span_done || line_s == LINE_STOP || line_s == LINE_N1) begin
               state_d = LT_RX_IDLE;
               err_c   = 1'b1;
            end
         end
         LT_TG_BRIDGE: begin
            mult = 3'd5;
            if (span_done) state_d = LT_TG_MARK;
         end
         LT_TG_MARK:   if (span_done) state_d = LT_TX_STOP;
         default:      state_d = RST_ST;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= RST_ST;
         rel_q   <= 1'b0;
         acc_q   <= 1'b0;
         err_q   <= 1'b0;
      end else begin
         state_q <= state_d;
         rel_q   <= (state_q == LT_GO) && span_done;
         acc_q   <= (state_q == LT_TG_MARK) && span_done;
         err_q   <= err_c;
      end
   end

   always_comb begin
      case (state_q)
         LT_REQ_A, LT_REQ_C, LT_TG_MARK: lp_tx = LINE_P1;
         LT_REQ_B, LT_GO, LT_TG_BRIDGE:  lp_tx = LINE_BRIDGE;
         default:                        lp_tx = LINE_STOP;
      endcase
   end

   always_comb begin
      case (state_q)
         LT_TX_STOP, LT_REQ_A, LT_REQ_B, LT_REQ_C, LT_GO,
         LT_TG_BRIDGE, LT_TG_MARK: drive_en = 1'b1;
         default:                  drive_en = 1'b0;
      endcase
   end

   assign lane_owned = (state_q == LT_TX_STOP);
   assign rel_done   = rel_q;
   assign acc_done   = acc_q;
   assign ta_err     = err_q;

   // R9
   en_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(drive_en) |-> ($past(line_s) == LINE_BRIDGE));

   // R9
   en_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(drive_en) |-> ($past(lp_tx) == LINE_BRIDGE));

   // R2
   rel_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rel_done |-> (!drive_en && $past(drive_en)));

   // R6
   acc_mark_chk: assert property (@(posedge clk) disable iff (!rst_n)
      acc_done |-> ($past(lp_tx) == LINE_P1 && lp_tx == LINE_STOP && drive_en));

   // R5
   err_rx_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ta_err |-> (!drive_en && !lane_owned));

endmodule

// File: tb/lane_turnaround_bench.sv
module lane_turnaround_bench;

   typedef struct packed {
      logic        en;
      logic [1:0]  tx;
      logic [15:0] len;
   } seg_t;

   logic       clk = 1'b0;
   logic       rst_n;
   logic [7:0] lpx_cnt;
   logic       rel_req;
   logic [1:0] lp_rx;
   logic [1:0] lp_tx;
   logic       drive_en, lane_owned, rel_done, acc_done, ta_err;

   int   tests = 0;
   int   fails = 0;
   int   ecnt = 0;
   int   n_rel = 0, n_acc = 0, n_err = 0;
   int   rise_ecnt = -1;
   int   seg_start = 0;
   bit   mon_on = 1'b0;
   bit   have_prev = 1'b0;
   logic [2:0] prev_v, cur_v;
   seg_t exp_q[$];

   always #10 clk = ~clk;

   lane_turnaround u_lane_turnaround (
      .clk        (clk),
      .rst_n      (rst_n),
      .lpx_cnt    (lpx_cnt),
      .rel_req    (rel_req),
      .lp_rx      (lp_rx),
      .lp_tx      (lp_tx),
      .drive_en   (drive_en),
      .lane_owned (lane_owned),
      .rel_done   (rel_done),
      .acc_done   (acc_done),
      .ta_err     (ta_err)
   );

   always @(posedge clk) ecnt <= ecnt + 1;

   task automatic check(bit ok, string req, int act, int exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   endtask

   // monitor: closes output segments and compares them with the scoreboard
   always @(negedge clk) begin
      if (rst_n && mon_on) begin
         cur_v = {drive_en, lp_tx};
         if (!have_prev) begin
            have_prev = 1'b1;
            prev_v    = cur_v;
            seg_start = ecnt;
         end else if (cur_v != prev_v) begin
            if (exp_q.size() == 0) begin
               check(1'b0, "R9 unexpected change", int'(cur_v), int'(prev_v));
            end else begin
               seg_t e;
               int   len;
               e   = exp_q.pop_front();
               len = ecnt - seg_start;
               // R2 R6 R8: line state and its duration
               check({e.en, e.tx} == prev_v, "R2/R6 segment state", int'(prev_v), int'({e.en, e.tx}));
               if (e.len != 0)
                  check(len == int'(e.len), "R2/R6/R8 segment length", len, int'(e.len));
            end
            if (!prev_v[2] && cur_v[2]) rise_ecnt = ecnt;
            prev_v    = cur_v;
            seg_start = ecnt;
         end
         if (rel_done) n_rel++;
         if (acc_done) n_acc++;
         if (ta_err)   n_err++;
      end
   end

   task automatic push(logic en, logic [1:0] tx, int len);
      seg_t s;
      s.en  = en;
      s.tx  = tx;
      s.len = 16'(len);
      exp_q.push_back(s);
   endtask

   task automatic do_release(int le);
      int r0;
      push(1'b1, 2'b11, 0);
      push(1'b1, 2'b10, le);
      push(1'b1, 2'b00, le);
      push(1'b1, 2'b10, le);
      push(1'b1, 2'b00, 4 * le);
      r0 = n_rel;
      @(negedge clk); rel_req = 1'b1;
      @(negedge clk); rel_req = 1'b0;
      repeat (7 * le + 3) @(negedge clk);
      // R2
      check(n_rel == r0 + 1, "R2 rel_done count", n_rel, r0 + 1);
      check(drive_en == 1'b0, "R2 released", int'(drive_en), 0);
      check(lp_tx == 2'b11, "R9 idle line", int'(lp_tx), 3);
   endtask

   task automatic do_accept(int le, int m, bit take);
      int a0, e0, k, want;
      if (take) begin
         push(1'b0, 2'b11, 0);
         push(1'b1, 2'b00, 5 * le);
         push(1'b1, 2'b10, le);
      end
      a0 = n_acc;
      e0 = n_err;
      rise_ecnt = -1;
      @(negedge clk); lp_rx = 2'b11;
      repeat (3) @(negedge clk);
      lp_rx = 2'b10;
      repeat (le) @(negedge clk);
      lp_rx = 2'b00;
      repeat (le) @(negedge clk);
      lp_rx = 2'b10;
      k = ecnt;
      repeat (m) @(negedge clk);
      lp_rx = 2'b00;
      repeat (9 * le + 4) @(negedge clk);
      lp_rx = 2'b11;
      repeat (4) @(negedge clk);
      if (take) begin
         want = 3 + ((m > le) ? m : le);
         // R4 R5: take-over edge inside the window
         check(rise_ecnt - k == want, "R4/R5 take latency", rise_ecnt - k, want);
         // R6
         check(n_acc == a0 + 1, "R6 acc_done count", n_acc, a0 + 1);
         check(lane_owned && drive_en && lp_tx == 2'b11, "R6 owned stop",
               int'({lane_owned, drive_en, lp_tx}), 15);
      end else begin
         // R5
         check(n_err == e0 + 1, "R5 ta_err count", n_err, e0 + 1);
         check(rise_ecnt == -1 && !drive_en, "R5 stays receiver", rise_ecnt, -1);
      end
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      check(1'b0, "watchdog", 0, 1);
      finish_run();
   end

   initial begin : main
      int r0;
      rst_n   = 1'b0;
      rel_req = 1'b0;
      lp_rx   = 2'b11;
      lpx_cnt = 8'd4;
      repeat (3) @(negedge clk);
      // R1
      check(drive_en && lp_tx == 2'b11 && lane_owned, "R1 reset owner",
            int'({drive_en, lp_tx, lane_owned}), 15);
      check(!rel_done && !acc_done && !ta_err, "R1 pulses low",
            int'({rel_done, acc_done, ta_err}), 0);
      rst_n = 1'b1;
      @(negedge clk);
      mon_on = 1'b1;

      // R7: far-end activity while owning
      lp_rx = 2'b00;
      repeat (6) @(negedge clk);
      lp_rx = 2'b10;
      repeat (6) @(negedge clk);
      check(drive_en && lp_tx == 2'b11 && lane_owned, "R7 line ignored",
            int'({drive_en, lp_tx, lane_owned}), 15);
      lp_rx = 2'b11;
      repeat (4) @(negedge clk);

      do_release(4);

      // R3: request while not owning
      r0 = n_rel;
      @(negedge clk); rel_req = 1'b1;
      @(negedge clk); rel_req = 1'b0;
      repeat (10) @(negedge clk);
      check(!drive_en && lp_tx == 2'b11 && n_rel == r0, "R3 request ignored",
            int'({drive_en, lp_tx}), 3);

      do_accept(4, 4, 1'b1);

      // R8: zero period count acts as one cycle
      lpx_cnt = 8'd0;
      do_release(1);
      lpx_cnt = 8'd3;

      do_accept(3, 1, 1'b1);
      do_release(3);
      do_accept(3, 6, 1'b1);
      do_release(3);
      do_accept(3, 7, 1'b0);
      do_accept(3, 3, 1'b1);

      repeat (4) @(negedge clk);
      check(exp_q.size() == 0, "R9 all segments seen", exp_q.size(), 0);
      finish_run();
   end

endmodule